// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block recovers characters from an asynchronous serial line. It watches the line for a falling edge, confirms the start bit half a bit time later, and then samples each following bit at its centre. The bit period comes from a divider input. The character length (7 or 8 bits), the bit order, the number of stop bits and the parity mode are configuration inputs. The transmitter on the same chip uses the same configuration inputs.

Each finished character goes into a data register. The register can be read in two ways: as a plain byte, or as a 16-bit word that also carries the parity and framing verdicts for that character. A status byte holds sticky flags for parity, framing and overrun errors. These flags clear when the status is read or when the block's clock enable is dropped. A one-cycle interrupt pulse marks each character.

Top module: `serial_rx_core`

## Requirements
- R1: `data8` holds the last character. `data16` holds that character in bits 7:0, its framing-error flag in bit 8 and its parity-error flag in bit 9. Bits 15:10 read 0.
- R2: `status` bit 0 is overrun, bit 1 is framing error and bit 2 is parity error. Bit 3 is the overflow flag, which always reads 0 because there is no receive queue. Bits 7:4 read 0.
- R3: With `char8`=1 a character has 8 data bits. With `char8`=0 it has 7 data bits and bit 7 of the data reads 0. With `lsb_first`=1 the first data bit on the line is bit 0. With `lsb_first`=0 the first data bit is the most significant bit of the character (bit 7 or bit 6).
- R4: `par_mode` selects the parity mode. 00 means no parity bit is present. 01 means the parity bit must be 0. 10 means odd parity: data plus parity bit must hold an odd number of ones. 11 means even parity: data plus parity bit must hold an even number of ones. A mismatch sets the parity-error flag.
- R5: If the first stop bit is sampled low, the framing-error flag is set. With `two_stop`=1 the second stop bit period is not checked and cannot start a new character.
- R6: If a character completes while the previous one is still unread (no `rd_data` pulse since it arrived), the overrun flag is set. The new character replaces the old one.
- R7: Status flags are sticky. A `rd_status` pulse clears them, but an error that arrives in the same cycle still sets its flag. Dropping `clk_en` clears all flags and the data register.
- R8: While `rx_en`=0, no character is received and the data register does not change.
- R9: `rx_irq` is a one-cycle pulse for each received character. It is high in the first cycle in which the new data and flags are visible.
- R10: A start bit is accepted only if the line is still low `baud_div`/2 cycles after the falling edge is seen. A shorter low pulse produces no character.
- R11: One bit lasts `baud_div` clock cycles, for any `baud_div` of 4 or more.
- R12: After reset, `data8`, `data16` and `status` are 0 and `rx_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Block enable; low clears the data register and the status flags |
| rx_en | input | 1 | Receive enable |
| char8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| lsb_first | input | 1 | 1: least significant bit first |
| two_stop | input | 1 | 1: two stop bits |
| par_mode | input | 2 | 00 none, 01 forced zero, 10 odd, 11 even |
| baud_div | input | DIV_W | Clock cycles per bit (4 or more) |
| rxd | input | 1 | Serial input line, idle high |
| rd_data | input | 1 | Pulse: data register has been read |
| rd_status | input | 1 | Pulse: status has been read (clears the flags) |
| data8 | output | 8 | Received character |
| data16 | output | 16 | Character with framing flag (bit 8) and parity flag (bit 9) |
| status | output | 8 | Sticky error flags |
| rx_irq | output | 1 | One-cycle pulse per received character |

## Verification
Three situations are hard to reach from the ports: a line that stays low through the second stop bit, a start glitch that ends just before the mid-bit check, and a character whose parity bit is deliberately wrong in each of the three checking modes.

The bench builds every frame itself, bit by bit, from a character and a few corruption switches. The switches can flip the parity bit, drive the first stop bit low, or hold the second stop bit low. It sweeps all combinations of parity mode, length, bit order and stop count through these variants. It then runs all 256 byte values in one configuration.

The glitch test holds the line low for one cycle less than half a bit. Separate tests cover back-to-back unread characters and changes of the bit period.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_GAP
    } rx_state_e;

    // Status byte bit positions
    localparam int STAT_OVR  = 0;
    localparam int STAT_FRM  = 1;
    localparam int STAT_PAR  = 2;
    localparam int STAT_OVFL = 3;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             char8,
    input  logic             lsb_first,
    input  logic             two_stop,
    input  logic [1:0]       par_mode,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             rx_s,
    output logic             done,
    output logic [7:0]       chr,
    output logic             pe,
    output logic             fe
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        rx_state_e        state;
        logic [DIV_W-1:0] cnt;
        logic [3:0]       bitn;
        logic [7:0]       sh;
        logic             perr;
        logic             prev;
    } frm_t;

    frm_t             q, d;
    par_mode_e        pm;
    logic [DIV_W-1:0] bit_m1, half_m1;
    logic [3:0]       last_bit;
    logic [7:0]       assembled;
    logic             par_bad;
    logic             tick;

    always_comb begin
        pm        = par_mode_e'(par_mode);
        bit_m1    = baud_div - ONE;
        half_m1   = (baud_div >> 1) - ONE;
        last_bit  = char8 ? 4'd7 : 4'd6;
        tick      = (q.cnt == '0);
        assembled = char8     ? q.sh :
                    lsb_first ? {1'b0, q.sh[7:1]} : {1'b0, q.sh[6:0]};
        case (pm)
            PAR_ZERO: par_bad = rx_s;
            PAR_ODD:  par_bad = ~(^assembled ^ rx_s);
            PAR_EVEN: par_bad = ^assembled ^ rx_s;
            default:  par_bad = 1'b0;
        endcase

        d      = q;
        d.prev = rx_s;
        if (!tick) d.cnt = q.cnt - ONE;

        case (q.state)
            ST_IDLE: begin
                if (q.prev && !rx_s) begin
                    d.state = ST_START;
                    d.cnt   = half_m1;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (!rx_s) begin
                        d.state = ST_DATA;
                        d.cnt   = bit_m1;
                        d.bitn  = '0;
                        d.sh    = '0;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    d.sh   = lsb_first ? {rx_s, q.sh[7:1]} : {q.sh[6:0], rx_s};
                    d.cnt  = bit_m1;
                    d.bitn = q.bitn + 4'd1;
                    d.perr = 1'b0;
                    if (q.bitn == last_bit)
                        d.state = (pm == PAR_NONE) ? ST_STOP : ST_PAR;
                end
            end
            ST_PAR: begin
                if (tick) begin
                    d.perr  = par_bad;
                    d.cnt   = bit_m1;
                    d.state = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tick) begin
                    d.cnt   = bit_m1;
                    d.state = two_stop ? ST_GAP : ST_IDLE;
                end
            end
            ST_GAP: begin
                if (tick) d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase

        if (!run) begin
            d.state = ST_IDLE;
            d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done = run && (q.state == ST_STOP) && tick;
    assign chr  = assembled;
    assign pe   = q.perr;
    assign fe   = ~rx_s;

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             rx_en,
    input  logic             char8,
    input  logic             lsb_first,
    input  logic             two_stop,
    input  logic [1:0]       par_mode,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             rxd,
    input  logic             rd_data,
    input  logic             rd_status,
    output logic [7:0]       data8,
    output logic [15:0]      data16,
    output logic [7:0]       status,
    output logic             rx_irq
);

    typedef struct packed {
        logic [7:0] data;
        logic       pe_flag;
        logic       fe_flag;
        logic       full;
        logic       st_ovr;
        logic       st_frm;
        logic       st_par;
        logic       irq;
    } core_t;

    core_t      q, d;
    logic       rx_s;
    logic       f_done, f_pe, f_fe;
    logic [7:0] f_chr;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    serial_rx_frame #(.DIV_W(DIV_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (clk_en && rx_en),
        .char8    (char8),
        .lsb_first(lsb_first),
        .two_stop (two_stop),
        .par_mode (par_mode),
        .baud_div (baud_div),
        .rx_s     (rx_s),
        .done     (f_done),
        .chr      (f_chr),
        .pe       (f_pe),
        .fe       (f_fe)
    );

    always_comb begin
        d     = q;
        d.irq = f_done;
        if (rd_data) d.full = 1'b0;
        if (rd_status) begin
            d.st_ovr = 1'b0;
            d.st_frm = 1'b0;
            d.st_par = 1'b0;
        end
        if (f_done) begin
            d.data    = f_chr;
            d.pe_flag = f_pe;
            d.fe_flag = f_fe;
            d.full    = 1'b1;
            if (q.full && !rd_data) d.st_ovr = 1'b1;
            if (f_pe) d.st_par = 1'b1;
            if (f_fe) d.st_frm = 1'b1;
        end
        if (!clk_en) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        data8             = q.data;
        data16            = {6'b0, q.pe_flag, q.fe_flag, q.data};
        status            = '0;
        status[STAT_OVR]  = q.st_ovr;
        status[STAT_FRM]  = q.st_frm;
        status[STAT_PAR]  = q.st_par;
        status[STAT_OVFL] = 1'b0;
        rx_irq            = q.irq;
    end

endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clk_en,
    input logic        rx_en,
    input logic        char8,
    input logic        rd_status,
    input logic [15:0] data16,
    input logic [7:0]  status,
    input logic        rx_irq
);

    // R9: interrupt lasts one cycle
    a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R8: no character while reception is off
    a_r8_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_irq);

    // R7: clock enable low clears everything
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> (status == 8'h00 && data16 == 16'h0000 && !rx_irq));

    // R7: status read clears unless a new character lands
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> (rx_irq || status[2:0] == 3'b000));

    // R3: seven-bit characters read bit 7 as zero
    a_r3_seven_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !char8) |-> !data16[7]);

    // R1: per-character flags reach the sticky status
    a_r1_par_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && data16[9]) |-> status[2]);

    a_r1_frm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && data16[8]) |-> status[1]);

endmodule

bind serial_rx_core serial_rx_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .rx_en    (rx_en),
    .char8    (char8),
    .rd_status(rd_status),
    .data16   (data16),
    .status   (status),
    .rx_irq   (rx_irq)
);

// File: tb/serial_rx_core_bench.sv
`timescale 1ns/1ps
module serial_rx_core_bench;

    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en = 1'b1, rx_en = 1'b1;
    logic             char8 = 1'b1, lsb_first = 1'b1, two_stop = 1'b0;
    logic [1:0]       par_mode = 2'b00;
    logic [DIV_W-1:0] baud_div = 16'd8;
    logic             rxd = 1'b1;
    logic             rd_data = 1'b0, rd_status = 1'b0;
    logic [7:0]       data8;
    logic [15:0]      data16;
    logic [7:0]       status;
    logic             rx_irq;

    int         checks = 0, fails = 0, irq_n = 0;
    logic [7:0] cap8;
    logic [15:0] cap16;
    logic       finished = 1'b0;

    always #10 clk = ~clk;

    serial_rx_core #(.DIV_W(DIV_W)) u_serial_rx_core (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .rx_en(rx_en),
        .char8(char8), .lsb_first(lsb_first), .two_stop(two_stop),
        .par_mode(par_mode), .baud_div(baud_div), .rxd(rxd),
        .rd_data(rd_data), .rd_status(rd_status),
        .data8(data8), .data16(data16), .status(status), .rx_irq(rx_irq)
    );

    always @(negedge clk) begin
        if (rst_n && rx_irq) begin
            irq_n = irq_n + 1;
            cap8  = data8;
            cap16 = data16;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (int'(baud_div)) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] ch, input logic bad_par,
                              input logic bad_stop, input logic second_low);
        int nb;
        logic [7:0] m;
        logic pb;
        nb = char8 ? 8 : 7;
        m  = char8 ? ch : {1'b0, ch[6:0]};
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(lsb_first ? m[i] : m[nb-1-i]);
        if (par_mode != 2'b00) begin
            case (par_mode)
                2'b01:   pb = 1'b0;
                2'b10:   pb = ~(^m);
                default: pb = ^m;
            endcase
            drive_bit(pb ^ bad_par);
        end
        drive_bit(~bad_stop);
        if (two_stop) drive_bit(~second_low);
        drive_bit(1'b1);
    endtask

    task automatic pulse_reads();
        rd_data = 1'b1; rd_status = 1'b1;
        @(negedge clk);
        rd_data = 1'b0; rd_status = 1'b0;
        @(negedge clk);
    endtask

    // Send one frame and check every view of it
    task automatic frame_check(input logic [7:0] ch, input logic bad_par,
                               input logic bad_stop, input logic second_low);
        int n0;
        logic [7:0] exp;
        logic ep, ef;
        n0  = irq_n;
        exp = char8 ? ch : {1'b0, ch[6:0]};
        ep  = bad_par && (par_mode != 2'b00);
        ef  = bad_stop;
        send_frame(ch, bad_par, bad_stop, second_low);
        repeat (4) @(negedge clk);
        check(irq_n == n0 + 1, "R9 irq count", irq_n - n0, 1);
        check(cap8 == exp, "R3 data8", cap8, exp);
        check(cap16 == {6'b0, ep, ef, exp}, "R1/R4/R5 data16", cap16, {6'b0, ep, ef, exp});
        check(status == {5'b0, ep, ef, 1'b0}, "R2 status", status, {5'b0, ep, ef, 1'b0});
        pulse_reads();
        check(status == 8'h00, "R7 cleared by read", status, 0);
    endtask

    initial begin
        #(20 * 200000);
        $display("FAIL watchdog actual=0 expected=1");
        fails++;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n0;
        logic [7:0] vals [6];
        vals = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h5A};
        repeat (3) @(negedge clk);
        // R12 reset state
        check(data16 == 16'h0 && data8 == 8'h0, "R12 data", data16, 0);
        check(status == 8'h0 && !rx_irq, "R12 status", status, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3/R4/R5 sweep over every configuration
        for (int pm = 0; pm < 4; pm++)
            for (int c8 = 0; c8 < 2; c8++)
                for (int lf = 0; lf < 2; lf++)
                    for (int ts = 0; ts < 2; ts++) begin
                        par_mode = 2'(pm); char8 = c8[0];
                        lsb_first = lf[0]; two_stop = ts[0];
                        for (int k = 0; k < 6; k++)
                            frame_check(vals[k], k == 2 || k == 5, k == 3,
                                        (ts == 1) && (k == 4));
                    end

        // R11 bit time follows the divider, exhaustive byte sweep
        par_mode = 2'b11; char8 = 1'b1; lsb_first = 1'b1; two_stop = 1'b0;
        baud_div = 16'd5;
        for (int v = 0; v < 256; v++) frame_check(8'(v), 1'b0, 1'b0, 1'b0);
        baud_div = 16'd4;
        frame_check(8'hC3, 1'b0, 1'b0, 1'b0);
        baud_div = 16'd12;
        frame_check(8'h96, 1'b1, 1'b0, 1'b0);
        baud_div = 16'd8;

        // R10 glitch shorter than half a bit is rejected
        n0 = irq_n;
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check(irq_n == n0, "R10 glitch rejected", irq_n - n0, 0);
        check(data8 == 8'h96, "R10 data kept", data8, 8'h96);
        frame_check(8'h42, 1'b0, 1'b0, 1'b0);

        // R6 overrun: second character without reading the first
        send_frame(8'h11, 1'b0, 1'b0, 1'b0);
        send_frame(8'h22, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check(data8 == 8'h22, "R6 overwritten", data8, 8'h22);
        check(status == 8'h01, "R6/R2 overrun flag", status, 8'h01);

        // R7 dropping clock enable clears
        clk_en = 1'b0;
        @(negedge clk);
        clk_en = 1'b1;
        @(negedge clk);
        check(status == 8'h00, "R7 clk_en clears status", status, 0);
        check(data16 == 16'h0, "R7 clk_en clears data", data16, 0);

        // R8 receive disabled
        frame_check(8'h5E, 1'b0, 1'b0, 1'b0);
        rx_en = 1'b0;
        n0 = irq_n;
        send_frame(8'hE7, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check(irq_n == n0, "R8 no irq when off", irq_n - n0, 0);
        check(data8 == 8'h5E, "R8 data unchanged", data8, 8'h5E);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        frame_check(8'h7E, 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule